// File: doc/BRIEF.md
# In-Place Compute SRAM Sub-Array

This block is a cycle-level digital model of an SRAM sub-array. Its rows serve as plain storage through read and write accesses. In a compute access it also enables two rows at the same time, so one access returns bitwise results across a whole row. A second row decoder makes the dual-row access possible. Sensing the true bitline of every column against a reference yields the AND of the two rows. Sensing the complement bitline in the same access yields their NOR. XOR, equality, the zero test, copy and inversion are all built from those two results.

Every access walks the same phase sequence: a precharge (or bitline drive) cycle, a wordline cycle and a sense cycle. A controller state machine steps through that sequence with the states IDLE, PRECHARGE, WORDLINE, SENSE, WB_DRIVE, WB_WORDLINE and WB_SENSE.

The transitions are as follows. IDLE moves to PRECHARGE when a legal command is taken. PRECHARGE always moves to WORDLINE, and WORDLINE always moves to SENSE. SENSE returns to IDLE, except for copy and invert, which go on to WB_DRIVE. WB_DRIVE moves to WB_WORDLINE, WB_WORDLINE moves to WB_SENSE, and WB_SENSE returns to IDLE. A write commits its row in WORDLINE, and a write-back commits in WB_WORDLINE. Result registers load at the end of WORDLINE.

Top module: `ics_subarray`

## Requirements
- R1: Reset clears every row to zero and drives cmd_ready high, res_valid low, and res_and, res_nor, res_xor and res_flag to zero. This holds even when reset arrives in the middle of an access.
- R2: A command is taken only on a rising edge where cmd_valid and cmd_ready are both high. cmd_ready is low from that edge until the access finishes, and commands presented while it is low have no effect.
- R3: A single access passes through precharge, wordline and sense in consecutive cycles. res_valid is high for exactly one cycle, starting at the third rising edge counted from the accepting edge.
- R4: Code 0 (read) returns row_a: res_and equals the row, res_nor equals its complement, res_xor is zero.
- R5: Code 1 (write) stores wr_data into row_a. It raises res_valid after three edges and leaves res_and, res_nor, res_xor and res_flag unchanged.
- R6: Code 2 (compute) returns res_and = A AND B, res_nor = NOR(A, B) and res_xor = A XOR B, where A is row_a and B is row_b.
- R7: For code 2, res_flag is 1 exactly when the two rows are equal, which means every XOR bit is zero.
- R8: A compute with row_a equal to row_b returns the stored row on res_and, the same as a read.
- R9: Code 3 (zero test) returns the same outputs as a read of row_a. For codes 0, 3, 4 and 5, res_flag is 1 exactly when row_a is all zeros.
- R10: Code 4 (copy) reads row_a and then writes that value into row_b in a second three-phase access. res_valid rises only at the sixth edge, and the outputs carry the row_a read results.
- R11: Code 5 (invert) writes the complement of row_a into row_b using the same six-edge two-access sequence, and the outputs carry the row_a read results.
- R12: Codes 6 and 7 are ignored: cmd_ready stays high, no res_valid pulse appears, no row changes and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code: 0 read, 1 write, 2 compute, 3 zero test, 4 copy, 5 invert |
| row_a | input | clog2(ROWS) | First row address (source or target of single-row operations) |
| row_b | input | clog2(ROWS) | Second row address (compute partner or copy/invert destination) |
| wr_data | input | COLS | Row data for a write |
| cmd_ready | output | 1 | Controller idle and able to take a command |
| res_valid | output | 1 | One-cycle pulse marking the final sense cycle |
| res_and | output | COLS | Sensed AND (or read data) |
| res_nor | output | COLS | Sensed NOR (or complement of read data) |
| res_xor | output | COLS | Per-column XOR derived from AND and NOR |
| res_flag | output | 1 | Equality for compute, zero test otherwise |

## Verification
The bench targets several corner cases, each with a known failure mode:

- A compute on a single address. A design that decoded row_b regardless of command would break the read identity.
- Copy and invert. A controller that raised res_valid after the first access, or wrote back the NOR instead of the AND (or the reverse), shows up through a later compute that compares the rows.
- Unused codes followed by a read of the addressed row. This catches a decoder that still wrote or pulsed.
- Commands held on the inputs during a busy access. This exposes a controller that takes a second command early.
- A reset in the middle of an access. This shows whether the array and the outputs really return to zero.

// File: rtl/ics_pkg.sv
`timescale 1ns/1ps
package ics_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_LOGIC  = 3'd2,
        OP_ZTEST  = 3'd3,
        OP_COPY   = 3'd4,
        OP_INVERT = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRECHARGE,
        PH_WORDLINE,
        PH_SENSE,
        PH_WB_DRIVE,
        PH_WB_WORDLINE,
        PH_WB_SENSE
    } phase_e;

    localparam logic [2:0] OP_LAST = 3'd5;

    function automatic logic op_legal(input logic [2:0] code);
        return code <= OP_LAST;
    endfunction

    function automatic logic op_writes_back(input op_e op);
        return (op == OP_COPY) || (op == OP_INVERT);
    endfunction

    function automatic logic op_dual_row(input op_e op);
        return op == OP_LOGIC;
    endfunction

endpackage

// File: rtl/ics_row_store.sv
`timescale 1ns/1ps
module ics_row_store #(
    parameter int ROWS = 16,
    parameter int COLS = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(ROWS)-1:0] wr_row,
    input  logic [COLS-1:0]         wr_row_data,
    input  logic [$clog2(ROWS)-1:0] rd_row_a,
    input  logic [$clog2(ROWS)-1:0] rd_row_b,
    output logic [COLS-1:0]         rd_a,
    output logic [COLS-1:0]         rd_b
);

    logic [COLS-1:0] cells [ROWS];

    // Row array: cleared on reset, one row written per enabled cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                cells[r] <= '0;
            end
        end else if (wr_en) begin
            cells[wr_row] <= wr_row_data;
        end
    end

    // Two independent decoders: both wordlines may be active together.
    assign rd_a = cells[rd_row_a];
    assign rd_b = cells[rd_row_b];

    // R5: a committed row is visible on the port that addresses it next cycle.
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_row == rd_row_a)) |=>
            ((rd_a == $past(wr_row_data)) || (rd_row_a != $past(rd_row_a))));

endmodule

// File: rtl/ics_bitline_sense.sv
`timescale 1ns/1ps
module ics_bitline_sense #(
    parameter int COLS = 512
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] row_t,
    input  logic [COLS-1:0] row_u,
    output logic [COLS-1:0] and_o,
    output logic [COLS-1:0] nor_o,
    output logic [COLS-1:0] xor_o,
    output logic            eq_o,
    output logic            zero_o
);

    // Per-column single-ended sensing: the true bitline stays high only if
    // both cells hold 1; the complement bitline stays high only if both hold 0.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign and_o[c] = row_t[c] & row_u[c];
        assign nor_o[c] = ~(row_t[c] | row_u[c]);
        assign xor_o[c] = ~(and_o[c] | nor_o[c]);
    end

    assign eq_o   = ~|xor_o;
    assign zero_o = &nor_o;

    // R6: the derived difference matches the two activated rows.
    a_r6_xor_from_rows: assert property (@(posedge clk) disable iff (!rst_n)
        xor_o == (row_t ^ row_u));

    // R7: the match flag tracks row equality.
    a_r7_eq_tracks_rows: assert property (@(posedge clk) disable iff (!rst_n)
        eq_o == (row_t == row_u));

    // R9: the zero flag is set only when both activated rows are empty.
    a_r9_zero_tracks_rows: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == ((row_t == '0) && (row_u == '0)));

endmodule

// File: rtl/ics_phase_fsm.sv
`timescale 1ns/1ps
module ics_phase_fsm
    import ics_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    output logic       cmd_ready,
    output logic       accept,
    output logic       sense_strobe,
    output logic       write_strobe,
    output logic       wb_select,
    output logic       res_valid,
    output op_e        op_q
);

    phase_e state, state_nx;

    // Next-phase selection
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_IDLE:        if (cmd_valid && op_legal(cmd_op)) state_nx = PH_PRECHARGE;
            PH_PRECHARGE:   state_nx = PH_WORDLINE;
            PH_WORDLINE:    state_nx = PH_SENSE;
            PH_SENSE:       state_nx = op_writes_back(op_q) ? PH_WB_DRIVE : PH_IDLE;
            PH_WB_DRIVE:    state_nx = PH_WB_WORDLINE;
            PH_WB_WORDLINE: state_nx = PH_WB_SENSE;
            PH_WB_SENSE:    state_nx = PH_IDLE;
            default:        state_nx = PH_IDLE;
        endcase
    end

    // State register and captured command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            op_q  <= OP_READ;
        end else begin
            state <= state_nx;
            if (accept) begin
                op_q <= op_e'(cmd_op);
            end
        end
    end

    // Phase outputs
    always_comb begin
        cmd_ready    = 1'b0;
        accept       = 1'b0;
        sense_strobe = 1'b0;
        write_strobe = 1'b0;
        wb_select    = 1'b0;
        res_valid    = 1'b0;
        unique case (state)
            PH_IDLE: begin
                cmd_ready = 1'b1;
                accept    = cmd_valid && op_legal(cmd_op);
            end
            PH_PRECHARGE: ;
            PH_WORDLINE: begin
                sense_strobe = (op_q != OP_WRITE);
                write_strobe = (op_q == OP_WRITE);
            end
            PH_SENSE:       res_valid = !op_writes_back(op_q);
            PH_WB_DRIVE:    wb_select = 1'b1;
            PH_WB_WORDLINE: begin
                wb_select    = 1'b1;
                write_strobe = 1'b1;
            end
            PH_WB_SENSE:    res_valid = 1'b1;
            default: ;
        endcase
    end

    // R3: phases follow one another without gaps.
    a_r3_pre_to_wordline: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_PRECHARGE) |=> (state == PH_WORDLINE));
    a_r3_wordline_to_sense: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_WORDLINE) |=> (state == PH_SENSE));
    // R3: the completion pulse lasts one cycle.
    a_r3_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R10: the write-back access keeps its own phase order.
    a_r10_wb_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_WB_DRIVE) |=> (state == PH_WB_WORDLINE));
    // R2: no command is taken while an access is in progress.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !cmd_ready);
    // R12: unused codes leave the controller idle.
    a_r12_unused_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !op_legal(cmd_op)) |=> cmd_ready);

endmodule

// File: rtl/ics_subarray.sv
`timescale 1ns/1ps
module ics_subarray
    import ics_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic [$clog2(ROWS)-1:0] row_a,
    input  logic [$clog2(ROWS)-1:0] row_b,
    input  logic [COLS-1:0]         wr_data,
    output logic                    cmd_ready,
    output logic                    res_valid,
    output logic [COLS-1:0]         res_and,
    output logic [COLS-1:0]         res_nor,
    output logic [COLS-1:0]         res_xor,
    output logic                    res_flag
);

    localparam int AW = $clog2(ROWS);

    logic            accept, sense_strobe, write_strobe, wb_select;
    op_e             op_q;
    logic [AW-1:0]   a_q, b_q, sense_b_row, wr_row;
    logic [COLS-1:0] wd_q, wr_row_data;
    logic [COLS-1:0] rd_a, rd_b;
    logic [COLS-1:0] and_w, nor_w, xor_w;
    logic            eq_w, zero_w;
    logic [COLS-1:0] and_q, nor_q, xor_q;
    logic            flag_q;

    ics_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_ready    (cmd_ready),
        .accept       (accept),
        .sense_strobe (sense_strobe),
        .write_strobe (write_strobe),
        .wb_select    (wb_select),
        .res_valid    (res_valid),
        .op_q         (op_q)
    );

    // Command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            wd_q <= '0;
        end else if (accept) begin
            a_q  <= row_a;
            b_q  <= row_b;
            wd_q <= wr_data;
        end
    end

    // Second decoder addresses row_b only for a dual-row compute.
    assign sense_b_row = op_dual_row(op_q) ? b_q : a_q;

    // Write path: a plain write targets row_a with the captured data;
    // a write-back targets row_b with the sensed AND (copy) or NOR (invert).
    assign wr_row      = wb_select ? b_q : a_q;
    assign wr_row_data = wb_select ? ((op_q == OP_INVERT) ? nor_q : and_q) : wd_q;

    ics_row_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (write_strobe),
        .wr_row      (wr_row),
        .wr_row_data (wr_row_data),
        .rd_row_a    (a_q),
        .rd_row_b    (sense_b_row),
        .rd_a        (rd_a),
        .rd_b        (rd_b)
    );

    ics_bitline_sense #(.COLS(COLS)) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .row_t  (rd_a),
        .row_u  (rd_b),
        .and_o  (and_w),
        .nor_o  (nor_w),
        .xor_o  (xor_w),
        .eq_o   (eq_w),
        .zero_o (zero_w)
    );

    // Sense-amplifier latches: loaded at the end of the wordline phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            and_q  <= '0;
            nor_q  <= '0;
            xor_q  <= '0;
            flag_q <= 1'b0;
        end else if (sense_strobe) begin
            and_q  <= and_w;
            nor_q  <= nor_w;
            xor_q  <= xor_w;
            flag_q <= op_dual_row(op_q) ? eq_w : zero_w;
        end
    end

    assign res_and  = and_q;
    assign res_nor  = nor_q;
    assign res_xor  = xor_q;
    assign res_flag = flag_q;

    // R6: every column reports exactly one of AND, NOR, XOR after a sensed access.
    a_r6_column_partition: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (op_q != OP_WRITE)) |->
            (((and_q & nor_q) == '0) && ((and_q | nor_q | xor_q) == '1)));

    // R10: a copy write-back carries the current contents of the source row.
    a_r10_copy_matches_source: assert property (@(posedge clk) disable iff (!rst_n)
        (write_strobe && wb_select && (op_q == OP_COPY)) |-> (wr_row_data == rd_a));

endmodule

// File: tb/ics_subarray_test.sv
`timescale 1ns/1ps
module ics_subarray_test;

    localparam int ROWS = 8;
    localparam int COLS = 32;
    localparam int AW   = $clog2(ROWS);
    localparam int NV   = 17;

    // Stimulus table: code, row_a, row_b, write data, expected edges to res_valid (0 = none)
    localparam logic [2:0]      T_OP  [NV] = '{3'd1, 3'd1, 3'd0, 3'd2, 3'd2, 3'd3, 3'd3, 3'd4, 3'd2,
                                                3'd5, 3'd2, 3'd6, 3'd0, 3'd7, 3'd1, 3'd2, 3'd0};
    localparam int              T_A   [NV] = '{1, 2, 1, 1, 1, 3, 1, 1, 4, 2, 5, 1, 1, 2, 7, 7, 2};
    localparam int              T_B   [NV] = '{0, 0, 0, 2, 1, 0, 0, 4, 1, 5, 2, 1, 0, 2, 0, 0, 0};
    localparam logic [COLS-1:0] T_WD  [NV] = '{32'hF0F0_1234, 32'h0FF0_1234, 32'h0, 32'h0, 32'h0,
                                                32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                                32'hDEAD_BEEF, 32'h0, 32'h1234_5678, 32'hFFFF_FFFF,
                                                32'h0, 32'h0};
    localparam int              T_LAT [NV] = '{3, 3, 3, 3, 3, 3, 3, 6, 3, 6, 3, 0, 3, 0, 3, 3, 3};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = 3'd0;
    logic [AW-1:0]   row_a = '0;
    logic [AW-1:0]   row_b = '0;
    logic [COLS-1:0] wr_data = '0;
    logic            cmd_ready, res_valid, res_flag;
    logic [COLS-1:0] res_and, res_nor, res_xor;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [COLS-1:0] mdl [ROWS];
    logic [COLS-1:0] e_and = '0, e_nor = '0, e_xor = '0;
    logic            e_flag = 1'b0;

    ics_subarray #(.ROWS(ROWS), .COLS(COLS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .row_a     (row_a),
        .row_b     (row_b),
        .wr_data   (wr_data),
        .cmd_ready (cmd_ready),
        .res_valid (res_valid),
        .res_and   (res_and),
        .res_nor   (res_nor),
        .res_xor   (res_xor),
        .res_flag  (res_flag)
    );

    always #10 clk = ~clk;

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0:    return "R4";
            3'd1:    return "R5";
            3'd2:    return "R6";
            3'd3:    return "R9";
            3'd4:    return "R10";
            3'd5:    return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic model_clear();
        for (int r = 0; r < ROWS; r++) mdl[r] = '0;
        e_and = '0; e_nor = '0; e_xor = '0; e_flag = 1'b0;
    endtask

    // One command: drive, watch ten edges, then compare against the model.
    task automatic run_cmd(input logic [2:0] op, input int a, input int b,
                           input logic [COLS-1:0] wd, input int exp_lat);
        string           tag;
        string           ftag;
        int              lat;
        int              pulses;
        logic [COLS-1:0] c_and, c_nor, c_xor, va, vb;
        logic            c_flag;
        tag   = op_tag(op);
        ftag  = (op == 3'd2) ? "R7" : tag;
        if (op == 3'd2 && a == b) tag = "R8";
        lat = 0; pulses = 0;
        c_and = '0; c_nor = '0; c_xor = '0; c_flag = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        row_a = AW'(a); row_b = AW'(b); wr_data = wd;
        for (int n = 1; n <= 10; n++) begin
            @(posedge clk);
            #1;
            if (n == 1) begin
                check_eq((exp_lat == 0) ? "R12" : "R2", "ready after edge 1",
                         64'(cmd_ready), (exp_lat == 0) ? 64'd1 : 64'd0);
                cmd_valid = 1'b0;
            end
            if (res_valid) begin
                if (pulses == 0) begin
                    lat = n;
                    c_and = res_and; c_nor = res_nor; c_xor = res_xor; c_flag = res_flag;
                end
                pulses++;
            end
        end
        if (exp_lat == 0) begin
            c_and = res_and; c_nor = res_nor; c_xor = res_xor; c_flag = res_flag;
        end
        check_eq((exp_lat == 6) ? tag : ((exp_lat == 0) ? "R12" : "R3"), "edges to valid",
                 64'(lat), 64'(exp_lat));
        check_eq((exp_lat == 0) ? "R12" : "R3", "valid pulse count",
                 64'(pulses), (exp_lat == 0) ? 64'd0 : 64'd1);
        // Expected results from the requirements
        if (op <= 3'd5 && op != 3'd1) begin
            va = mdl[a];
            vb = (op == 3'd2) ? mdl[b] : va;
            e_and  = va & vb;
            e_nor  = ~(va | vb);
            e_xor  = va ^ vb;
            e_flag = (op == 3'd2) ? (va == vb) : (va == '0);
            if (op == 3'd4) mdl[b] = va;
            if (op == 3'd5) mdl[b] = ~va;
        end else if (op == 3'd1) begin
            mdl[a] = wd;
        end
        check_eq(tag, "res_and", 64'(c_and), 64'(e_and));
        check_eq(tag, "res_nor", 64'(c_nor), 64'(e_nor));
        check_eq(tag, "res_xor", 64'(c_xor), 64'(e_xor));
        check_eq(ftag, "res_flag", 64'(c_flag), 64'(e_flag));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        model_clear();
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_eq("R1", "ready at reset", 64'(cmd_ready), 64'd1);
        check_eq("R1", "valid at reset", 64'(res_valid), 64'd0);
        check_eq("R1", "and at reset",   64'(res_and),   64'd0);
        check_eq("R1", "nor at reset",   64'(res_nor),   64'd0);
        check_eq("R1", "xor at reset",   64'(res_xor),   64'd0);
        check_eq("R1", "flag at reset",  64'(res_flag),  64'd0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            run_cmd(T_OP[i], T_A[i], T_B[i], T_WD[i], T_LAT[i]);
        end

        // R2: a write held on the inputs during a busy read is not taken.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; row_a = AW'(4); row_b = '0;
        for (int n = 1; n <= 8; n++) begin
            @(posedge clk);
            #1;
            if (n == 1) begin
                cmd_op = 3'd1; row_a = AW'(6); wr_data = 32'hAAAA_5555;
            end
            if (n == 3) begin
                check_eq("R2", "held read valid", 64'(res_valid), 64'd1);
                check_eq("R2", "held read data", 64'(res_and), 64'(mdl[4]));
                cmd_valid = 1'b0;
            end
        end
        e_and = mdl[4]; e_nor = ~mdl[4]; e_xor = '0; e_flag = (mdl[4] == '0);
        run_cmd(3'd0, 6, 0, '0, 3);
        check_eq("R2", "row 6 untouched", 64'(res_and), 64'd0);

        // R1: reset in the middle of a compute clears array and outputs.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd2; row_a = AW'(1); row_b = AW'(2);
        @(posedge clk); #1; cmd_valid = 1'b0;
        @(posedge clk); #1; rst_n = 1'b0;
        @(negedge clk);
        check_eq("R1", "ready in reset", 64'(cmd_ready), 64'd1);
        check_eq("R1", "valid in reset", 64'(res_valid), 64'd0);
        check_eq("R1", "and in reset",   64'(res_and),   64'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        run_cmd(3'd0, 1, 0, '0, 3);
        check_eq("R1", "row 1 cleared", 64'(res_and), 64'd0);

        done = 1'b1;
        finish_run();
    end

endmodule